// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block chooses where the two ALU operands of the instruction in the execute stage come from in a five-stage in-order pipeline. There are three possible sources for each operand. The first is the value read from the register file during decode. The second is the result held by the instruction one stage ahead, in the memory stage. The third is the result of the instruction two stages ahead, in writeback. The block compares the two source register numbers of the executing instruction with the destination numbers of the two older instructions. A stage is a candidate only if its register-write flag is set. It then produces one 2-bit select code per operand.

A producer that writes register zero is never used, because that register always reads as zero. When both older instructions write the register that an operand needs, the memory-stage result is chosen because it is the more recent one. Each operand is decided on its own, so one operand can take the memory-stage value while the other takes the writeback value.

The top level also contains the two operand multiplexers, so the selected data is visible at the ports. All paths are combinational. Stalling for loads whose data is not yet available, the register file itself and the ALU belong to other blocks.

Top module: `opbyp_unit`

## Requirements
- R1: When the memory stage has its write flag set, a nonzero destination and a destination equal to an operand's source number, that operand's select is 2'b10.
- R2: When the memory stage does not qualify for an operand, and writeback has its write flag set, a nonzero destination and a destination equal to that operand's source number, the select is 2'b01.
- R3: When neither stage qualifies for an operand, its select is 2'b00 and the operand carries the register-file value.
- R4: A memory stage whose write flag is clear never causes forwarding, even when its destination matches.
- R5: A writeback stage whose write flag is clear never causes forwarding, even when its destination matches.
- R6: A destination of register 0 never causes forwarding from either stage, even when the write flag is set and the source is also 0.
- R7: When both stages qualify for the same operand, the memory stage (newest producer) wins with 2'b10. This includes three back-to-back writes to one register.
- R8: Operand A is matched only against the A source number and operand B only against the B source number. The two selects can differ in the same cycle.
- R9: The operand data output equals register-file data for 2'b00, writeback data for 2'b01 and memory data for 2'b10. The code 2'b11 never appears.
- R10: Selects and operand data depend only on the current inputs, with no clock and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | IDX_W | Source register number for operand A of the executing instruction |
| src_b_idx | input | IDX_W | Source register number for operand B of the executing instruction |
| mem_wr_en | input | 1 | Register-write flag of the memory-stage instruction |
| mem_dst_idx | input | IDX_W | Destination register of the memory-stage instruction |
| mem_result | input | DATA_W | Result held by the memory-stage instruction |
| wb_wr_en | input | 1 | Register-write flag of the writeback-stage instruction |
| wb_dst_idx | input | IDX_W | Destination register of the writeback-stage instruction |
| wb_result | input | DATA_W | Result held by the writeback-stage instruction |
| rf_a_data | input | DATA_W | Register-file value read for operand A |
| rf_b_data | input | DATA_W | Register-file value read for operand B |
| sel_a | output | 2 | Source select for operand A (00 file, 01 writeback, 10 memory) |
| sel_b | output | 2 | Source select for operand B (00 file, 01 writeback, 10 memory) |
| opnd_a | output | DATA_W | Selected operand A data |
| opnd_b | output | DATA_W | Selected operand B data |

## Verification
Each result is due in the same cycle as its stimulus, because the block holds no registers. The bench drives a new set of inputs on every falling clock edge and compares the selects and operand data a short settling delay later, still before the next rising edge. The memory and writeback fields come from a small shift chain of instructions in the bench. This makes back-to-back dependent sequences, such as three successive writes to one register, appear in the stages exactly as a real pipeline would present them. Each check is then made in the cycle where the dependent instruction sits in execute.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;

  // Operand source select codes; the encoding is decoded by the operand muxes.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_WB      = 2'b01,
    SRC_MEM     = 2'b10
  } src_sel_e;

  localparam int unsigned NUM_OPND  = 2;
  localparam int unsigned NUM_STAGE = 2;

  // Stage ordering, newest first; used as priority rank.
  localparam int unsigned STG_MEM = 0;
  localparam int unsigned STG_WB  = 1;

endpackage

// File: rtl/opbyp_stage_cmp.sv
module opbyp_stage_cmp #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             wr_en,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_idx,
  output logic             live,
  output logic             hit
);

  // A producer is live when it writes a register other than the hardwired zero.
  function automatic logic producer_live(input logic we, input logic [IDX_W-1:0] dst);
    return we && (dst != '0);
  endfunction

  function automatic logic index_equal(input logic [IDX_W-1:0] x, input logic [IDX_W-1:0] y);
    return ~|(x ^ y);
  endfunction

  always_comb begin
    live = producer_live(wr_en, dst_idx);
    hit  = live && index_equal(dst_idx, src_idx);
  end

endmodule

// File: rtl/opbyp_prio.sv
module opbyp_prio
  import opbyp_pkg::*;
(
  input  logic     mem_hit,
  input  logic     wb_hit,
  output src_sel_e sel,
  output logic     wb_shadowed
);

  // Newest producer wins: the memory stage masks any writeback match.
  function automatic src_sel_e pick_source(input logic newer, input logic older);
    src_sel_e r;
    if (newer)      r = SRC_MEM;
    else if (older) r = SRC_WB;
    else            r = SRC_REGFILE;
    return r;
  endfunction

  always_comb begin
    sel         = pick_source(mem_hit, wb_hit);
    wb_shadowed = mem_hit && wb_hit;
  end

endmodule

// File: rtl/opbyp_mux.sv
module opbyp_mux
  import opbyp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  src_sel_e          sel,
  input  logic [DATA_W-1:0] rf_data,
  input  logic [DATA_W-1:0] mem_data,
  input  logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] out_data
);

  always_comb begin
    unique case (sel)
      SRC_MEM: out_data = mem_data;
      SRC_WB:  out_data = wb_data;
      default: out_data = rf_data;
    endcase
  end

endmodule

// File: rtl/opbyp_unit.sv
module opbyp_unit
  import opbyp_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic              mem_wr_en,
  input  logic [IDX_W-1:0]  mem_dst_idx,
  input  logic [DATA_W-1:0] mem_result,
  input  logic              wb_wr_en,
  input  logic [IDX_W-1:0]  wb_dst_idx,
  input  logic [DATA_W-1:0] wb_result,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int unsigned NSTG = NUM_STAGE;
  localparam int unsigned NOPD = NUM_OPND;

  // Per-stage producer fields, indexed by stage rank (newest first).
  logic [NSTG-1:0]            stg_we;
  logic [NSTG-1:0][IDX_W-1:0] stg_dst;

  // Per-operand inputs and outputs.
  logic [NOPD-1:0][IDX_W-1:0]  opd_src;
  logic [NOPD-1:0][DATA_W-1:0] opd_rf;
  logic [NOPD-1:0][DATA_W-1:0] opd_out;
  src_sel_e                    opd_sel [NOPD];

  // Named internal events, observed by the checker.
  logic [NOPD-1:0][NSTG-1:0] stg_hit;
  logic [NOPD-1:0][NSTG-1:0] stg_live;
  logic [NOPD-1:0]           wb_shadowed;

  always_comb begin
    stg_we[STG_MEM]  = mem_wr_en;
    stg_dst[STG_MEM] = mem_dst_idx;
    stg_we[STG_WB]   = wb_wr_en;
    stg_dst[STG_WB]  = wb_dst_idx;
    opd_src[0]       = src_a_idx;
    opd_src[1]       = src_b_idx;
    opd_rf[0]        = rf_a_data;
    opd_rf[1]        = rf_b_data;
  end

  for (genvar o = 0; o < NOPD; o++) begin : g_opd
    for (genvar s = 0; s < NSTG; s++) begin : g_stg
      opbyp_stage_cmp #(.IDX_W(IDX_W)) u_cmp (
        .wr_en   (stg_we[s]),
        .dst_idx (stg_dst[s]),
        .src_idx (opd_src[o]),
        .live    (stg_live[o][s]),
        .hit     (stg_hit[o][s])
      );
    end

    opbyp_prio u_prio (
      .mem_hit     (stg_hit[o][STG_MEM]),
      .wb_hit      (stg_hit[o][STG_WB]),
      .sel         (opd_sel[o]),
      .wb_shadowed (wb_shadowed[o])
    );

    opbyp_mux #(.DATA_W(DATA_W)) u_mux (
      .sel      (opd_sel[o]),
      .rf_data  (opd_rf[o]),
      .mem_data (mem_result),
      .wb_data  (wb_result),
      .out_data (opd_out[o])
    );
  end

  always_comb begin
    sel_a  = opd_sel[0];
    sel_b  = opd_sel[1];
    opnd_a = opd_out[0];
    opnd_b = opd_out[1];
  end

endmodule

// File: rtl/opbyp_unit_chk.sv
module opbyp_unit_chk #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic [IDX_W-1:0]  src_a_idx,
  input logic [IDX_W-1:0]  src_b_idx,
  input logic              mem_wr_en,
  input logic [IDX_W-1:0]  mem_dst_idx,
  input logic [DATA_W-1:0] mem_result,
  input logic              wb_wr_en,
  input logic [IDX_W-1:0]  wb_dst_idx,
  input logic [DATA_W-1:0] wb_result,
  input logic [DATA_W-1:0] rf_a_data,
  input logic [DATA_W-1:0] rf_b_data,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [1:0]        shadow
);

  always_comb begin
    // R1: a qualifying memory-stage producer routes memory data
    a_r1_mem_route_a: assert (!(mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_a_idx) || sel_a == 2'b10)
      else $error("R1 operand A");
    a_r1_mem_route_b: assert (!(mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_b_idx) || sel_b == 2'b10)
      else $error("R1 operand B");
    // R6: nothing is forwarded for a zero source register
    a_r6_zero_src_a: assert (src_a_idx != '0 || sel_a == 2'b00) else $error("R6 operand A");
    a_r6_zero_src_b: assert (src_b_idx != '0 || sel_b == 2'b00) else $error("R6 operand B");
    // R4 and R5: a disabled writer is never the chosen source
    a_r4_mem_gated: assert (mem_wr_en || (sel_a != 2'b10 && sel_b != 2'b10)) else $error("R4");
    a_r5_wb_gated: assert (wb_wr_en || (sel_a != 2'b01 && sel_b != 2'b01)) else $error("R5");
    // R7: a shadowed writeback match leaves the memory stage selected
    a_r7_newest_a: assert (!shadow[0] || sel_a == 2'b10) else $error("R7 operand A");
    a_r7_newest_b: assert (!shadow[1] || sel_b == 2'b10) else $error("R7 operand B");
    // R9: data follows the select and the unused code never appears
    a_r9_data_a: assert ((sel_a == 2'b00 && opnd_a == rf_a_data) || (sel_a == 2'b01 && opnd_a == wb_result)
                         || (sel_a == 2'b10 && opnd_a == mem_result)) else $error("R9 operand A");
    a_r9_data_b: assert ((sel_b == 2'b00 && opnd_b == rf_b_data) || (sel_b == 2'b01 && opnd_b == wb_result)
                         || (sel_b == 2'b10 && opnd_b == mem_result)) else $error("R9 operand B");
    // R2: a writeback match with no memory match routes writeback data
    a_r2_wb_route_a: assert (!(wb_wr_en && wb_dst_idx != '0 && wb_dst_idx == src_a_idx
                               && !(mem_wr_en && mem_dst_idx == src_a_idx)) || sel_a == 2'b01)
      else $error("R2 operand A");
  end

endmodule

bind opbyp_unit opbyp_unit_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .src_a_idx   (src_a_idx),
  .src_b_idx   (src_b_idx),
  .mem_wr_en   (mem_wr_en),
  .mem_dst_idx (mem_dst_idx),
  .mem_result  (mem_result),
  .wb_wr_en    (wb_wr_en),
  .wb_dst_idx  (wb_dst_idx),
  .wb_result   (wb_result),
  .rf_a_data   (rf_a_data),
  .rf_b_data   (rf_b_data),
  .sel_a       (sel_a),
  .sel_b       (sel_b),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b),
  .shadow      (wb_shadowed)
);

// File: tb/opbyp_unit_test.sv
module opbyp_unit_test;

  localparam int IW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [IW-1:0] src_a_idx, src_b_idx, mem_dst_idx, wb_dst_idx;
  logic          mem_wr_en, wb_wr_en;
  logic [DW-1:0] mem_result, wb_result, rf_a_data, rf_b_data;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b;

  opbyp_unit #(.IDX_W(IW), .DATA_W(DW)) uut (
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .mem_wr_en(mem_wr_en), .mem_dst_idx(mem_dst_idx), .mem_result(mem_result),
    .wb_wr_en(wb_wr_en), .wb_dst_idx(wb_dst_idx), .wb_result(wb_result),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Bench pipeline: queues of older instructions, newest at the front.
  int q_dst[$];
  int q_we[$];
  int q_val[$];

  // Reference: scan producers from newest to oldest; first live match wins.
  function automatic int ref_sel(int src, int mwe, int mdst, int wwe, int wdst);
    int prod_we[2];
    int prod_dst[2];
    int code[2];
    prod_we[0] = mwe; prod_dst[0] = mdst; code[0] = 2;
    prod_we[1] = wwe; prod_dst[1] = wdst; code[1] = 1;
    for (int k = 0; k < 2; k++)
      if (prod_we[k] != 0 && prod_dst[k] != 0 && prod_dst[k] == src) return code[k];
    return 0;
  endfunction

  task automatic expect_eq(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int ea, eb;
    longint da, db;
    ea = ref_sel(int'(src_a_idx), int'(mem_wr_en), int'(mem_dst_idx), int'(wb_wr_en), int'(wb_dst_idx));
    eb = ref_sel(int'(src_b_idx), int'(mem_wr_en), int'(mem_dst_idx), int'(wb_wr_en), int'(wb_dst_idx));
    da = (ea == 2) ? longint'(mem_result) : (ea == 1) ? longint'(wb_result) : longint'(rf_a_data);
    db = (eb == 2) ? longint'(mem_result) : (eb == 1) ? longint'(wb_result) : longint'(rf_b_data);
    expect_eq(tag, "sel_a", longint'(sel_a), longint'(ea));
    expect_eq(tag, "sel_b", longint'(sel_b), longint'(eb));
    expect_eq(tag, "opnd_a", longint'(opnd_a), da);
    expect_eq(tag, "opnd_b", longint'(opnd_b), db);
  endtask

  // One cycle: drive at the falling edge, compare after settling.
  task automatic drive(int sa, int sb, int mwe, int md, int wwe, int wd, string tag);
    @(negedge clk);
    cyc++;
    src_a_idx = IW'(sa); src_b_idx = IW'(sb);
    mem_wr_en = mwe[0];  mem_dst_idx = IW'(md);
    wb_wr_en  = wwe[0];  wb_dst_idx  = IW'(wd);
    mem_result = 32'hA000_0000 + 32'(cyc);
    wb_result  = 32'h0B00_0000 + 32'(cyc);
    rf_a_data  = 32'h00C0_0000 + 32'(cyc);
    rf_b_data  = 32'h000D_0000 + 32'(cyc);
    #2;
    compare(tag);
  endtask

  // Issue an instruction into execute; older ones occupy memory and writeback.
  task automatic issue(int sa, int sb, int we, int dst, string tag);
    int mwe = 0, md = 0, wwe = 0, wd = 0;
    if (q_dst.size() > 0) begin mwe = q_we[0]; md = q_dst[0]; end
    if (q_dst.size() > 1) begin wwe = q_we[1]; wd = q_dst[1]; end
    drive(sa, sb, mwe, md, wwe, wd, tag);
    q_dst.push_front(dst); q_we.push_front(we); q_val.push_front(cyc);
    if (q_dst.size() > 2) begin void'(q_dst.pop_back()); void'(q_we.pop_back()); void'(q_val.pop_back()); end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    src_a_idx = '0; src_b_idx = '0; mem_wr_en = 1'b0; mem_dst_idx = '0;
    wb_wr_en = 1'b0; wb_dst_idx = '0; mem_result = '0; wb_result = '0;
    rf_a_data = '0; rf_b_data = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    expect_eq("R3", "reset sel_a", longint'(sel_a), 0);
    expect_eq("R3", "reset sel_b", longint'(sel_b), 0);

    drive(3, 4, 1, 3, 0, 0, "R1");     // memory match on A
    drive(7, 9, 1, 9, 0, 0, "R1");     // memory match on B
    drive(6, 2, 0, 0, 1, 6, "R2");     // writeback match on A
    drive(1, 2, 1, 5, 1, 8, "R3");     // no match at all
    drive(3, 3, 0, 3, 0, 3, "R4");     // both disabled
    drive(3, 3, 0, 3, 1, 3, "R4");     // memory disabled, writeback takes it
    drive(4, 4, 1, 4, 0, 4, "R5");     // writeback disabled
    drive(0, 0, 1, 0, 1, 0, "R6");     // zero destinations, zero sources
    drive(0, 5, 1, 0, 1, 5, "R6");     // memory writes r0, writeback still valid
    drive(8, 8, 1, 8, 1, 8, "R7");     // both stages match
    drive(10, 11, 1, 10, 1, 11, "R8"); // A from memory, B from writeback
    drive(12, 13, 1, 13, 1, 12, "R8"); // crossed
    drive(14, 15, 1, 16, 1, 17, "R10");

    // Three back-to-back writes to r1 (R7 pipeline sequence).
    q_dst.delete(); q_we.delete(); q_val.delete();
    issue(20, 21, 0, 0, "R7");
    issue(22, 23, 0, 0, "R7");
    issue(1, 2, 1, 1, "R7");
    issue(1, 3, 1, 1, "R7");
    issue(1, 4, 1, 1, "R7");
    issue(1, 1, 0, 0, "R7");

    // Load of destination zero followed by uses of r0 (R6 pipeline sequence).
    issue(5, 6, 1, 0, "R6");
    issue(0, 0, 1, 0, "R6");
    issue(0, 0, 0, 0, "R6");

    // Broad sweep over a small register range to force collisions (R9).
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 4095));
      drive(r % 4, (r / 4) % 4, (r / 16) % 2, (r / 32) % 4, (r / 128) % 2, (r / 256) % 4, "R9");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule